// File: doc/BRIEF.md
# Programmable Channel-List Scanner

This block steps a multiplexed analog-to-digital front end through a sequence of entries that the host programs beforehand. Each entry names an analog input channel and a gain code for a programmable amplifier. The channel select and the gain select come from the contents of a small list memory, not from the index counter. The list can therefore visit channels in any order, repeat a channel to sample it more often, and give each visit its own gain.

The host loads entries and the index of the last used entry through a simple write port while scanning is disabled. Once scanning is enabled, each conversion-start pulse from the pacing source moves the index on by one entry. The advance happens at the start of the conversion, so the multiplexer and amplifier can settle on the next entry while the current one is converting. A tag output gives the index of the entry being converted, so each sample can be labelled. After the programmed last entry the index goes back to entry 0.

Top module: `chan_list_scanner`

## Requirements
- R1: After reset the index and the tag are 0, the last-entry index is 0, every list entry is 0, and so the channel and gain selects read 0.
- R2: `mux_chan` and `pga_gain` always show the channel field and the gain field of the list entry at the current index. The bench programs each field through `wr_chan` and `wr_gain`.
- R3: On a clock edge where `scan_en` and `conv_start` are both high, the index moves to the next entry. The selects show that entry from the cycle after the edge. While `conv_start` is low the index holds.
- R4: On such an edge `cur_idx` takes the index that was current before the advance, which is the entry now being converted. It holds until the next accepted start.
- R5: When the index equals the programmed last-entry index, the next accepted start sets it to 0.
- R6: Writes to list entries and to the last-entry index are ignored while `scan_en` is high.
- R7: While `scan_en` is low, `conv_start` has no effect, and the index and `cur_idx` are held at 0. Scanning therefore always begins at entry 0.
- R8: Entries need not be in order and may repeat a channel. The list 2,7,2,5 produces that channel sequence and then repeats it.
- R9: With a last-entry index of 0, the scan stays on entry 0. With a last-entry index of 15, all 16 entries are visited before the index wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one list entry |
| wr_addr | input | 4 | Entry index to write |
| wr_chan | input | 4 | Channel field of the written entry |
| wr_gain | input | 2 | Gain field of the written entry |
| len_we | input | 1 | Write the last-entry index |
| len_last | input | 4 | Index of the last used entry |
| scan_en | input | 1 | Enables scanning; when low, holds the index at 0 |
| conv_start | input | 1 | Conversion-start pulse from the pacing source |
| mux_chan | output | 4 | Channel select for the next conversion |
| pga_gain | output | 2 | Gain select for the next conversion |
| cur_idx | output | 4 | Index of the entry being converted |

## Verification
The assertions treat every cycle in which `conv_start` is high as a separate conversion start. A start held high for several cycles therefore advances the index several times. They also take for granted that the last-entry index changes only while scanning is disabled, which the block itself enforces.

The stimulus drives every input on the falling clock edge and gives each start pulse a width of exactly one cycle. Some writes are issued while scanning is enabled; this exercises the lock that the assertions rely on.

// File: rtl/chan_list_scanner.sv
module chan_list_scanner #(
  parameter int CH_W   = 4,
  parameter int GAIN_W = 2,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ENT_W = CH_W + GAIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [GAIN_W-1:0] wr_gain,
  input  logic              len_we,
  input  logic [IDX_W-1:0]  len_last,
  input  logic              scan_en,
  input  logic              conv_start,
  output logic [CH_W-1:0]   mux_chan,
  output logic [GAIN_W-1:0] pga_gain,
  output logic [IDX_W-1:0]  cur_idx
);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] idx, last_idx;
  logic             step;

  assign step = scan_en && conv_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      last_idx <= '0;
    end else if (!scan_en) begin
      if (wr_en)  mem[wr_addr] <= {wr_chan, wr_gain};
      if (len_we) last_idx     <= len_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !scan_en) begin
      idx     <= '0;
      cur_idx <= '0;
    end else if (step) begin
      cur_idx <= idx;
      idx     <= (idx == last_idx) ? '0 : idx + 1'b1;
    end
  end

  assign {mux_chan, pga_gain} = mem[idx];

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    step && idx != last_idx |=> idx == $past(idx) + 1'b1);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en && !conv_start |=> $stable(idx));

  a_r4_tag: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cur_idx == $past(idx));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    step && idx == last_idx |=> idx == '0);

  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> idx <= last_idx);

  a_r6_locked: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> $stable(last_idx));

  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> idx == '0 && cur_idx == '0);

endmodule

// File: tb/sim_chan_list_scanner.sv
module sim_chan_list_scanner;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, len_we = 0, scan_en = 0, conv_start = 0;
  logic [3:0] wr_addr = 0, wr_chan = 0, len_last = 0;
  logic [1:0] wr_gain = 0;
  logic [3:0] mux_chan, cur_idx;
  logic [1:0] pga_gain;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chan_list_scanner u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_chan(wr_chan), .wr_gain(wr_gain), .len_we(len_we), .len_last(len_last),
    .scan_en(scan_en), .conv_start(conv_start), .mux_chan(mux_chan),
    .pga_gain(pga_gain), .cur_idx(cur_idx));

  // row: conv(1) chan(4) gain(2) tag(4)
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 4'd7, 2'd0, 4'd0},
    {1'b1, 4'd2, 2'd3, 4'd1},
    {1'b1, 4'd5, 2'd2, 4'd2},
    {1'b1, 4'd2, 2'd1, 4'd3},
    {1'b0, 4'd2, 2'd1, 4'd3},
    {1'b1, 4'd7, 2'd0, 4'd0},
    {1'b1, 4'd2, 2'd3, 4'd1},
    {1'b0, 4'd2, 2'd3, 4'd1}
  };

  task automatic check(string req, logic [3:0] ch, logic [1:0] g, logic [3:0] t);
    checks++;
    if (mux_chan !== ch || pga_gain !== g || cur_idx !== t) begin
      fails++;
      $display("FAIL %s: got chan=%0d gain=%0d tag=%0d, expected chan=%0d gain=%0d tag=%0d",
               req, mux_chan, pga_gain, cur_idx, ch, g, t);
    end
  endtask

  task automatic put(logic [3:0] a, logic [3:0] c, logic [1:0] g);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_chan = c; wr_gain = g;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_last(logic [3:0] l);
    @(negedge clk); len_we = 1; len_last = l;
    @(negedge clk); len_we = 0;
  endtask

  task automatic pulse(logic c);
    @(negedge clk); conv_start = c;
    @(negedge clk); conv_start = 0;
  endtask

  task automatic set_en(logic e);
    @(negedge clk); scan_en = e;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset", 4'd0, 2'd0, 4'd0);

    put(0, 2, 1); put(1, 7, 0); put(2, 2, 3); put(3, 5, 2);
    set_last(3);
    check("R2 entry0 shown", 4'd2, 2'd1, 4'd0);
    pulse(1);
    check("R7 start ignored when disabled", 4'd2, 2'd1, 4'd0);

    set_en(1);
    check("R7 scan begins at entry0", 4'd2, 2'd1, 4'd0);
    foreach (VEC[i]) begin
      pulse(VEC[i][10]);
      check("R3/R4/R5/R8 vector", VEC[i][9:6], VEC[i][5:4], VEC[i][3:0]);
    end

    // R6: writes during scan ignored
    put(1, 15, 3);
    set_last(0);
    set_en(0);
    check("R7 disable clears index and tag", 4'd2, 2'd1, 4'd0);
    set_en(1);
    pulse(1);
    check("R6 entry1 unchanged", 4'd7, 2'd0, 4'd0);
    pulse(1); pulse(1); pulse(1);
    check("R6 length unchanged, R5 wrap", 4'd2, 2'd1, 4'd3);

    // R9 single entry
    set_en(0);
    set_last(0);
    set_en(1);
    pulse(1);
    check("R9 single entry stays", 4'd2, 2'd1, 4'd0);
    pulse(1);
    check("R9 single entry stays again", 4'd2, 2'd1, 4'd0);

    // R9 full depth
    set_en(0);
    put(15, 9, 2);
    set_last(15);
    set_en(1);
    for (int k = 0; k < 15; k++) pulse(1);
    check("R9 reaches entry15", 4'd9, 2'd2, 4'd14);
    pulse(1);
    check("R9 wraps after entry15", 4'd2, 2'd1, 4'd15);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule